// File: doc/BRIEF.md
# Synchronous Burst SRAM with Pipelined or Flow-Through Reads

This block models a synchronous static RAM, 64 bits wide, whose depth is set by an address-width parameter (a 16-bit address gives 65,536 words). Every input (address, chip enables, strobes, write enables, write data and the mode pins) is captured in a register on the rising clock edge, and the array is accessed on the following edge. It behaves like a block RAM with a small front end.

An access starts when one of two address strobes is sampled low. The processor-side strobe always starts a read. The controller-side strobe starts a read, or a write when write enables are present. After that, an advance input walks a two-bit beat counter through a four-word block. The beats go in either interleaved or linear order. Writes go to single 8-bit lanes, or to the whole word through a global write. Read data either leaves straight from the array register (flow-through), or passes through one more output register (pipelined).

Output enable gates the data bus without waiting for a clock. Dropping a secondary chip enable, or raising the snooze input, blanks the output within one cycle.

Top module: `burst_sram`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `q_drive` is 0 and `q` is all zeros.
- R2: A read started by a strobe sampled at edge E drives data from edge E+1 when `flow_thru` is 1, and from edge E+2 when it is 0. Before that, `q_drive` stays 0 when the output was blank.
- R3: With `order_lin` low (interleaved), beat k of a burst reads the word whose two low address bits are the start's low bits XOR k. The upper address bits keep their start value.
- R4: With `order_lin` high (linear), beat k reads low bits (start + k) mod 4. The burst wraps inside its four-word block, and the upper address bits keep their start value.
- R5: While a burst runs, a cycle with `adv_n` low and no strobe moves to the next beat. A cycle with `adv_n` high and no strobe accesses the current beat again.
- R6: With `gw_n` high and `bwe_n` low, a write changes only the lanes whose `bsel_n` bit is low. Bit i of `bsel_n` controls data bits 8i+7 down to 8i, and the other lanes keep their contents.
- R7: With `gw_n` low, a write stores all 64 bits whatever `bwe_n` and `bsel_n` hold.
- R8: When both strobes are sampled low in one cycle, the access is a read of `addr`, and no data is written.
- R9: With `oe_n` high, `q` is zero and `q_drive` is 0 at once, without a clock edge. Lowering `oe_n` again restores the data.
- R10: If `ce2` low or `ce3_n` high is sampled at edge E, `q_drive` is 0 from edge E+1, and the burst ends so that later advances start nothing. A strobe sampled with `ce_n` high starts no access.
- R11: While `sleep` is sampled high, strobes and writes are ignored (the array is unchanged), and `q_drive` is 0 from the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address for a strobe cycle |
| wdata | input | LANES*LANE_W | Write data |
| ce_n | input | 1 | Primary chip enable, active low, qualifies strobes |
| ce2 | input | 1 | Secondary chip enable, active high |
| ce3_n | input | 1 | Secondary chip enable, active low |
| ads_cpu_n | input | 1 | Processor-side address strobe, active low, read only |
| ads_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| bsel_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| order_lin | input | 1 | Burst order: 0 interleaved, 1 linear |
| flow_thru | input | 1 | Read path: 1 flow-through, 0 pipelined |
| sleep | input | 1 | Snooze: accesses ignored, output blank |
| q | output | LANES*LANE_W | Read data, zero when not driven |
| q_drive | output | 1 | High when `q` carries valid read data |

## Verification
Reads start from a blanked output, so the first cycle in which `q_drive` rises separates the flow-through latency from the pipelined one. Four-beat bursts start at low bits 2 and 3, in both orders. This tells an XOR walk from an incrementing one, and shows that the wrap stays inside the block. An advance pattern with hold cycles tells a repeated beat from a step.

Writes are checked with a lane mask of alternating lanes, with a global write whose lane selects are all inactive, and with both strobes together. A reread of the word separates written lanes from kept lanes. Deselect, snooze and a strobe with `ce_n` high each hit a running or starting access. The check looks at whether `q_drive` drops in the next cycle and stays down.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  // registered control inputs, captured every rising edge
  typedef struct packed {
    logic ce_n;
    logic ce2;
    logic ce3_n;
    logic ads_cpu_n;
    logic ads_ctl_n;
    logic adv_n;
    logic gw_n;
    logic bwe_n;
    logic lin;
    logic flow;
    logic sleep;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{ce_n: 1'b1, ce2: 1'b0, ce3_n: 1'b1,
                                ads_cpu_n: 1'b1, ads_ctl_n: 1'b1, adv_n: 1'b1,
                                gw_n: 1'b1, bwe_n: 1'b1, lin: 1'b0,
                                flow: 1'b0, sleep: 1'b0};

  // low address bits of beat k for a burst starting at low bits s
  function automatic logic [1:0] beat_lo(input logic [1:0] s,
                                         input logic [1:0] k,
                                         input logic       lin);
    return lin ? (s + k) : (s ^ k);
  endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              ctl,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [LANES-1:0]  r_bsel_n,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [LANES-1:0]  lane_we,
  output logic              rd_en,
  output logic              kill
);

  logic [ADDR_W-1:0] base;
  logic [1:0]        cnt;
  logic              active;

  logic sec_ok, awake, strobe, start, cont_ok, step, hold;
  logic [1:0] beat_k;
  logic [LANES-1:0] lanes;

  always_comb begin
    sec_ok  = ctl.ce2 & ~ctl.ce3_n;
    awake   = ~ctl.sleep;
    strobe  = ~ctl.ads_cpu_n | ~ctl.ads_ctl_n;
    start   = awake & sec_ok & ~ctl.ce_n & strobe;
    cont_ok = awake & sec_ok & active & ~strobe;
    step    = cont_ok & ~ctl.adv_n;
    hold    = cont_ok & ctl.adv_n;
    beat_k  = step ? cnt + 2'd1 : cnt;
    acc_addr = start ? r_addr
                     : {base[ADDR_W-1:2], beat_lo(base[1:0], beat_k, ctl.lin)};
    if (!ctl.gw_n)       lanes = '1;
    else if (!ctl.bwe_n) lanes = ~r_bsel_n;
    else                 lanes = '0;
    // processor-side strobe wins and forces a read
    lane_we = ((start & ctl.ads_cpu_n) | step | hold) ? lanes : '0;
    rd_en   = (start | step | hold) & (lane_we == '0);
    kill    = ~sec_ok | ctl.sleep;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base   <= '0;
      cnt    <= '0;
      active <= 1'b0;
    end else if (start) begin
      base   <= r_addr;
      cnt    <= '0;
      active <= 1'b1;
    end else if (step) begin
      cnt <= cnt + 2'd1;
    end else if (awake && !sec_ok) begin
      active <= 1'b0;
    end
  end

  a_r5_step_advances: assert property (@(posedge clk) disable iff (rst)
    step |=> (cnt == $past(cnt) + 2'd1));

  a_r10_deselect_ends: assert property (@(posedge clk) disable iff (rst)
    (awake && !sec_ok) |=> !active);

  a_r8_cpu_strobe_reads: assert property (@(posedge clk) disable iff (rst)
    (start && !ctl.ads_cpu_n) |-> (lane_we == '0 && rd_en));

endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        lane_we,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // byte-lane write enables and a registered read port: block-RAM shaped
  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (lane_we[i]) mem[addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
    end
    if (rd_en) rdata <= mem[addr];
  end

endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              kill,
  input  logic              flow,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] mem_q,
  output logic [DATA_W-1:0] q,
  output logic              q_drive
);

  logic              rd1, rd2;
  logic [DATA_W-1:0] pipe_q;
  logic              valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd1 <= 1'b0;
      rd2 <= 1'b0;
    end else begin
      rd1 <= rd_en;
      rd2 <= rd1 & ~kill;
    end
  end

  always_ff @(posedge clk) begin
    pipe_q <= mem_q;
  end

  always_comb begin
    valid   = flow ? rd1 : rd2;
    q_drive = ~oe_n & valid;
    q       = q_drive ? (flow ? mem_q : pipe_q) : '0;
  end

  a_r2_pipe_follows_flow: assert property (@(posedge clk) disable iff (rst)
    rd2 |-> $past(rd1));

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    ce_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    ads_cpu_n,
  input  logic                    ads_ctl_n,
  input  logic                    adv_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bsel_n,
  input  logic                    oe_n,
  input  logic                    order_lin,
  input  logic                    flow_thru,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] q,
  output logic                    q_drive
);

  localparam int DATA_W = LANES * LANE_W;

  ctl_t              r_ctl;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata;
  logic [LANES-1:0]  r_bsel_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_ctl    <= CTL_IDLE;
      r_bsel_n <= '1;
    end else begin
      r_ctl    <= '{ce_n: ce_n, ce2: ce2, ce3_n: ce3_n, ads_cpu_n: ads_cpu_n,
                    ads_ctl_n: ads_ctl_n, adv_n: adv_n, gw_n: gw_n,
                    bwe_n: bwe_n, lin: order_lin, flow: flow_thru,
                    sleep: sleep};
      r_bsel_n <= bsel_n;
    end
    r_addr  <= addr;
    r_wdata <= wdata;
  end

  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  lane_we;
  logic              rd_en, kill;
  logic [DATA_W-1:0] mem_q;

  burst_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst(rst), .ctl(r_ctl), .r_addr(r_addr), .r_bsel_n(r_bsel_n),
    .acc_addr(acc_addr), .lane_we(lane_we), .rd_en(rd_en), .kill(kill)
  );

  sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .rd_en(rd_en), .addr(acc_addr), .lane_we(lane_we),
    .wdata(r_wdata), .rdata(mem_q)
  );

  out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .rd_en(rd_en), .kill(kill), .flow(r_ctl.flow),
    .oe_n(oe_n), .mem_q(mem_q), .q(q), .q_drive(q_drive)
  );

  a_r9_oe_blanks: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (q == '0 && !q_drive));

  a_r10_deselect_blanks: assert property (@(posedge clk) disable iff (rst)
    (!ce2 || ce3_n) |-> ##2 !q_drive);

  a_r11_sleep_blanks: assert property (@(posedge clk) disable iff (rst)
    sleep |-> ##2 !q_drive);

endmodule

// File: tb/burst_sram_test.sv
module burst_sram_test;

  localparam int CLK_P  = 10;
  localparam int ADDR_W = 10;

  logic              clk = 1'b0;
  logic              rst;
  logic [ADDR_W-1:0] addr;
  logic [63:0]       wdata;
  logic              ce_n, ce2, ce3_n, ads_cpu_n, ads_ctl_n, adv_n;
  logic              gw_n, bwe_n, oe_n, order_lin, flow_thru, sleep;
  logic [7:0]        bsel_n;
  logic [63:0]       q;
  logic              q_drive;

  int checks = 0;
  int fails  = 0;

  burst_sram #(.ADDR_W(ADDR_W), .LANES(8), .LANE_W(8)) uut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .ce_n(ce_n), .ce2(ce2),
    .ce3_n(ce3_n), .ads_cpu_n(ads_cpu_n), .ads_ctl_n(ads_ctl_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .oe_n(oe_n),
    .order_lin(order_lin), .flow_thru(flow_thru), .sleep(sleep),
    .q(q), .q_drive(q_drive)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [63:0] pat(input int a);
    return {16'hC0DE, 16'(a), 16'hA5A5 ^ 16'(a * 3), ~16'(a)};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    ads_cpu_n = 1'b1; ads_ctl_n = 1'b1; adv_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; bsel_n = 8'hFF;
  endtask

  task automatic blank();
    ce2 = 1'b0; tick(); ce2 = 1'b1; tick();
  endtask

  task automatic write_word(input int a, input logic [63:0] d, input logic gw,
                            input logic [7:0] sel_n);
    addr = ADDR_W'(a); wdata = d; ads_ctl_n = 1'b0;
    gw_n = ~gw; bwe_n = 1'b0; bsel_n = sel_n;
    tick(); idle(); tick();
  endtask

  // R2: latency measured from a blank output
  task automatic read_single(input string req, input int a, input logic flow,
                             input logic [63:0] exp);
    flow_thru = flow; blank();
    addr = ADDR_W'(a); ads_cpu_n = 1'b0;
    tick(); idle();
    chk({req, " early"}, 64'(q_drive), 64'd0);
    tick();
    if (!flow) begin
      chk({req, " pipe early"}, 64'(q_drive), 64'd0);
      tick();
    end
    chk({req, " drive"}, 64'(q_drive), 64'd1);
    chk({req, " data"}, q, exp);
  endtask

  task automatic burst_read(input string req, input int a, input logic lin,
                            input logic flow, input logic [2:0] adv_pat,
                            input int e0, input int e1, input int e2, input int e3);
    int ex[4];
    ex[0] = e0; ex[1] = e1; ex[2] = e2; ex[3] = e3;
    order_lin = lin; flow_thru = flow; blank();
    addr = ADDR_W'(a); ads_cpu_n = 1'b0;
    tick(); ads_cpu_n = 1'b1;
    for (int t = 1; t <= 7; t++) begin
      int idx;
      idx = t - 2 - (flow ? 0 : 1);
      if (idx >= 0 && idx < 4) begin
        chk($sformatf("%s beat%0d drive", req, idx), 64'(q_drive), 64'd1);
        chk($sformatf("%s beat%0d", req, idx), q, pat(ex[idx]));
      end
      adv_n = (t <= 3) ? adv_pat[t-1] : 1'b1;
      tick();
    end
    adv_n = 1'b1;
  endtask

  task automatic test_reset();
    chk("R1 reset drive", 64'(q_drive), 64'd0);
    chk("R1 reset data", q, 64'd0);
    rst = 1'b0; tick();
    chk("R1 after reset drive", 64'(q_drive), 64'd0);
    chk("R1 after reset data", q, 64'd0);
  endtask

  task automatic test_latency();
    read_single("R2 flow", 5, 1'b1, pat(5));
    read_single("R2 pipe", 6, 1'b0, pat(6));
  endtask

  task automatic test_orders();
    burst_read("R3 interleaved pipe", 10, 1'b0, 1'b0, 3'b000, 10, 11, 8, 9);
    burst_read("R3 interleaved flow", 7, 1'b0, 1'b1, 3'b000, 7, 6, 5, 4);
    burst_read("R4 linear flow", 7, 1'b1, 1'b1, 3'b000, 7, 4, 5, 6);
    burst_read("R4 linear pipe", 30, 1'b1, 1'b0, 3'b000, 30, 31, 28, 29);
  endtask

  task automatic test_hold();
    // R5: hold, step, hold
    burst_read("R5 advance hold", 12, 1'b1, 1'b1, 3'b101, 12, 12, 13, 13);
  endtask

  task automatic test_byte_write();
    logic [63:0] x, y, e;
    x = 64'h1111_2222_3333_4444; y = 64'hAAAA_BBBB_CCCC_DDDD;
    write_word(20, x, 1'b1, 8'hFF);
    write_word(20, y, 1'b0, 8'b1111_0101);
    e = x; e[15:8] = y[15:8]; e[31:24] = y[31:24];
    read_single("R6 byte lanes", 20, 1'b1, e);
  endtask

  task automatic test_global_write();
    write_word(21, 64'h0123_4567_89AB_CDEF, 1'b1, 8'hFF);
    read_single("R7 global write", 21, 1'b1, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic test_priority();
    flow_thru = 1'b1; blank();
    addr = 10'd21; wdata = 64'hDEAD_BEEF_DEAD_BEEF;
    ads_cpu_n = 1'b0; ads_ctl_n = 1'b0; gw_n = 1'b0;
    tick(); idle(); tick();
    chk("R8 both strobes read drive", 64'(q_drive), 64'd1);
    chk("R8 both strobes read data", q, 64'h0123_4567_89AB_CDEF);
    read_single("R8 no write", 21, 1'b1, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic test_oe();
    read_single("R9 setup", 5, 1'b1, pat(5));
    #1 oe_n = 1'b1;
    #1 chk("R9 oe high data", q, 64'd0);
    chk("R9 oe high drive", 64'(q_drive), 64'd0);
    oe_n = 1'b0;
    #1 chk("R9 oe low data", q, pat(5));
  endtask

  task automatic test_deselect();
    flow_thru = 1'b0; order_lin = 1'b0; blank();
    addr = 10'd0; ads_cpu_n = 1'b0;
    tick(); ads_cpu_n = 1'b1; adv_n = 1'b0;
    tick(); ce2 = 1'b0;
    tick();
    chk("R10 beat0 before deselect", q, pat(0));
    ce2 = 1'b1;
    tick();
    chk("R10 ce2 blanks in one cycle", 64'(q_drive), 64'd0);
    tick(); tick();
    chk("R10 advance after deselect", 64'(q_drive), 64'd0);
    adv_n = 1'b1;
    read_single("R10 ce3 setup", 5, 1'b1, pat(5));
    ce3_n = 1'b1; tick(); ce3_n = 1'b0; tick();
    chk("R10 ce3_n blanks", 64'(q_drive), 64'd0);
    blank();
    ce_n = 1'b1; addr = 10'd3; ads_cpu_n = 1'b0;
    tick(); ce_n = 1'b0; idle(); tick(); tick();
    chk("R10 ce_n high no start", 64'(q_drive), 64'd0);
  endtask

  task automatic test_sleep();
    read_single("R11 setup", 5, 1'b1, pat(5));
    sleep = 1'b1; tick(); tick();
    chk("R11 sleep blanks", 64'(q_drive), 64'd0);
    write_word(22, 64'hFFFF_0000_FFFF_0000, 1'b1, 8'hFF);
    sleep = 1'b0; tick();
    read_single("R11 write ignored", 22, 1'b1, pat(22));
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; addr = '0; wdata = '0; ce_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    oe_n = 1'b0; order_lin = 1'b0; flow_thru = 1'b1; sleep = 1'b0;
    idle();
    repeat (3) tick();
    test_reset();
    for (int a = 0; a < 32; a++) write_word(a, pat(a), 1'b1, 8'hFF);
    test_latency();
    test_orders();
    test_hold();
    test_byte_write();
    test_global_write();
    test_priority();
    test_oe();
    test_deselect();
    test_sleep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule